// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Tail-Chaining

This block steps a processor core into and out of interrupt handlers. It keeps a set of pending request lines, each with a fixed priority, and picks the most urgent one. While a handler's context is being set up it counts out a fixed entry period. It then marks the core as running that handler until the core pulses a handler-done strobe. The block does not model instruction execution. It only says which handler is active, whether the main program may run, and which transition phase the core is in.

When a handler finishes and more work is pending, the block moves straight into the next handler through a short chaining transition. The main program gets no cycles in between. If a more urgent request turns up while an entry is under way, the entry switches to the new target and keeps its remaining cycles. The request that was displaced stays pending and is served later by chaining.

Top module: `irq_entry_seq`

## Requirements
- R1: On synchronous active-high reset the phase is MAIN (code 0), `main_run` is 1, `in_handler` is 0, `active_id` is 0 and no request is pending.
- R2: Priority is fixed per line: the pending line with the lowest index is always the one selected.
- R3: From MAIN, a non-empty pending set starts an entry. Phase ENTER (code 1) lasts exactly ENTRY_CYC cycles (default 12) with `main_run` low, and is followed by phase RUN (code 2) with `in_handler` high.
- R4: A request that becomes pending while a handler runs does not interrupt it. The running handler and `active_id` hold until `done` is sampled high in RUN, and `done` has no effect in any other phase.
- R5: When `done` is sampled in RUN and a request is pending, phase CHAIN (code 3) lasts exactly CHAIN_CYC cycles (default 6). `main_run` stays low for all of them, and RUN then follows for the most urgent pending line.
- R6: If a more urgent line becomes pending during ENTER, the target moves to that line without restarting the entry count. The displaced line stays pending and is later served through CHAIN.
- R7: When `done` is sampled in RUN and nothing is pending, phase EXIT (code 4) lasts exactly EXIT_CYC cycles (default 12), after which the phase returns to MAIN with `main_run` high.
- R8: A line leaves the pending set on the clock edge where its handler begins. A request on a line that is already pending is ignored, so each line is served once per time it becomes pending.
- R9: `active_id` shows the current target during ENTER and CHAIN, the running line during RUN, and 0 in MAIN and EXIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Request pulses, one bit per line; lower index is more urgent |
| done | input | 1 | Handler-finished strobe from the core |
| active_id | output | $clog2(N) | Target or running line number |
| in_handler | output | 1 | High while a handler runs |
| main_run | output | 1 | High while the main program may execute |
| phase | output | 3 | 0 MAIN, 1 ENTER, 2 RUN, 3 CHAIN, 4 EXIT |

## Verification
A request sampled at an edge becomes pending at that edge. The next edge starts ENTER, and RUN appears ENTRY_CYC edges later. A `done` sampled in RUN moves the phase at the very next edge. RUN then resumes CHAIN_CYC edges later, or MAIN returns EXIT_CYC edges later. The bench drives inputs on the falling edge and advances a cycle model by one step per rising edge. It compares every output half a cycle after each rising edge. The directed cases count phase cycles between those edges, so the latencies are checked exactly and not within a tolerance.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int N         = 8,
  parameter int ENTRY_CYC = 12,
  parameter int CHAIN_CYC = 6,
  parameter int EXIT_CYC  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 done,
  output logic [$clog2(N)-1:0] active_id,
  output logic                 in_handler,
  output logic                 main_run,
  output logic [2:0]           phase
);
  localparam int IDW  = $clog2(N);
  localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ((ENTRY_CYC > CHAIN_CYC) ? ENTRY_CYC : CHAIN_CYC)
                                               : ((EXIT_CYC > CHAIN_CYC) ? EXIT_CYC : CHAIN_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {MAIN = 3'd0, ENTER = 3'd1, RUN = 3'd2, CHAIN = 3'd3, EXIT = 3'd4} ph_t;

  ph_t            ph;
  logic [CW-1:0]  cnt;
  logic [N-1:0]   pend;
  logic [IDW-1:0] sel, cur;
  logic           any, start;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) sel = IDW'(i);
  end

  assign any   = |pend;
  assign start = (ph == ENTER && cnt == CW'(ENTRY_CYC - 1)) ||
                 (ph == CHAIN && cnt == CW'(CHAIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= MAIN;
      cnt  <= '0;
      pend <= '0;
      cur  <= '0;
    end else begin
      pend <= (pend | req) & ~(start ? (N'(1) << sel) : N'(0));
      if (start) begin
        ph  <= RUN;
        cur <= sel;
        cnt <= '0;
      end else begin
        unique case (ph)
          MAIN:  if (any) begin ph <= ENTER; cnt <= '0; end
          ENTER: cnt <= cnt + 1'b1;
          CHAIN: cnt <= cnt + 1'b1;
          RUN:   if (done) begin ph <= any ? CHAIN : EXIT; cnt <= '0; end
          EXIT:  if (cnt == CW'(EXIT_CYC - 1)) begin ph <= MAIN; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
          default: ph <= MAIN;
        endcase
      end
    end
  end

  assign phase      = ph;
  assign main_run   = (ph == MAIN);
  assign in_handler = (ph == RUN);
  assign active_id  = (ph == ENTER || ph == CHAIN) ? sel : (ph == RUN) ? cur : '0;

  AST_ENTER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ph == ENTER && cnt != CW'(ENTRY_CYC - 1)) |=> (ph == ENTER)); // R3
  AST_RUN_STICKS: assert property (@(posedge clk) disable iff (rst)
    (ph == RUN && !done) |=> (ph == RUN && $stable(active_id))); // R4
  AST_CHAIN_NO_MAIN: assert property (@(posedge clk) disable iff (rst)
    (ph == RUN && done && any) |=> (ph == CHAIN && !main_run)); // R5
  AST_TARGET_ONLY_UP: assert property (@(posedge clk) disable iff (rst)
    (ph == ENTER && cnt != CW'(ENTRY_CYC - 1)) |=> (active_id <= $past(active_id))); // R6
  AST_EXIT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ph == RUN && done && !any) |=> (ph == EXIT && !main_run)); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (in_handler && !pend[cur])); // R8
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int N = 8, EC = 12, CC = 6, XC = 12;

  logic clk = 1'b0, rst = 1'b1, done = 1'b0;
  logic [N-1:0] req = '0;
  logic [2:0] active_id, phase;
  logic in_handler, main_run;
  int checks = 0, fails = 0;

  int m_ph, m_cnt, m_cur;
  logic [N-1:0] m_pend;

  always #5 clk = ~clk;

  irq_entry_seq #(.N(N), .ENTRY_CYC(EC), .CHAIN_CYC(CC), .EXIT_CYC(XC)) u_dut (
    .clk(clk), .rst(rst), .req(req), .done(done), .active_id(active_id),
    .in_handler(in_handler), .main_run(main_run), .phase(phase));

  function automatic int lowest(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return 0;
  endfunction

  function automatic int exp_id();
    if (m_ph == 1 || m_ph == 3) return lowest(m_pend);
    if (m_ph == 2) return m_cur;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step_model(input logic [N-1:0] r, input logic d, input logic rs);
    logic [N-1:0] clr;
    int sel;
    clr = '0;
    sel = lowest(m_pend);
    if (rs) begin m_ph = 0; m_cnt = 0; m_pend = '0; m_cur = 0; return; end
    case (m_ph)
      0: if (m_pend != 0) begin m_ph = 1; m_cnt = 0; end
      1: if (m_cnt == EC - 1) begin m_ph = 2; m_cur = sel; clr[sel] = 1'b1; end else m_cnt++;
      2: if (d) begin m_ph = (m_pend != 0) ? 3 : 4; m_cnt = 0; end
      3: if (m_cnt == CC - 1) begin m_ph = 2; m_cur = sel; clr[sel] = 1'b1; end else m_cnt++;
      default: if (m_cnt == XC - 1) begin m_ph = 0; m_cnt = 0; end else m_cnt++;
    endcase
    m_pend = (m_pend | r) & ~clr;
  endtask

  task automatic tick(input logic [N-1:0] r, input logic d);
    req = r; done = d;
    step_model(r, d, rst);
    @(negedge clk);
    check(phase == 3'(m_ph), "R3/R5/R7 phase", phase, m_ph);
    check(active_id == 3'(exp_id()), "R2/R9 active_id", active_id, exp_id());
    check(main_run == (m_ph == 0), "R5 main_run", main_run, m_ph == 0);
    check(in_handler == (m_ph == 2), "R4 in_handler", in_handler, m_ph == 2);
  endtask

  task automatic count_phase(input int code, output int n, output int mr);
    n = 0; mr = 0;
    while (phase == 3'(code)) begin
      n++;
      if (main_run) mr++;
      tick('0, 1'b0);
    end
  endtask

  bit finished = 0;
  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, mr;
    void'($urandom(32'd4242));
    @(negedge clk);
    tick('0, 1'b0);
    tick('0, 1'b0);
    rst = 1'b0;
    check(phase == 3'd0 && main_run && !in_handler && active_id == 0, "R1 reset state", phase, 0);

    tick('0, 1'b1);
    check(phase == 3'd0, "R4 done ignored in MAIN", phase, 0);

    tick(8'h20, 1'b0);
    tick('0, 1'b0);
    count_phase(1, n, mr);
    check(n == EC, "R3 entry length", n, EC);
    check(mr == 0, "R3 main_run low in entry", mr, 0);
    check(active_id == 5, "R9 running id", active_id, 5);

    tick(8'h84, 1'b0);
    for (int i = 0; i < 5; i++) tick('0, 1'b0);
    check(in_handler && active_id == 5, "R4 no preempt", active_id, 5);
    tick('0, 1'b1);
    count_phase(3, n, mr);
    check(n == CC, "R5 chain length", n, CC);
    check(mr == 0, "R5 zero main cycles", mr, 0);
    check(active_id == 2, "R2 chained to most urgent", active_id, 2);
    tick('0, 1'b1);
    count_phase(3, n, mr);
    check(active_id == 7, "R5 second chain", active_id, 7);
    tick('0, 1'b1);
    count_phase(4, n, mr);
    check(n == XC, "R7 exit length", n, XC);
    check(main_run && phase == 0, "R7 back to main", phase, 0);

    tick(8'h40, 1'b0);
    tick('0, 1'b0);
    for (int i = 0; i < 4; i++) tick('0, 1'b0);
    tick(8'h02, 1'b0);
    count_phase(1, n, mr);
    check(n == EC - 5, "R6 remaining entry cycles kept", n, EC - 5);
    check(active_id == 1, "R6 redirected target", active_id, 1);
    tick('0, 1'b1);
    count_phase(3, n, mr);
    check(active_id == 6, "R6 displaced served by chain", active_id, 6);

    tick(8'h10, 1'b0);
    tick(8'h10, 1'b1);
    count_phase(3, n, mr);
    check(active_id == 4, "R8 pending line served", active_id, 4);
    tick('0, 1'b1);
    check(phase == 3'd4, "R8 repeat request ignored", phase, 4);
    count_phase(4, n, mr);

    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] r;
      r = ($urandom % 6 == 0) ? (N'(1) << ($urandom % N)) : '0;
      tick(r, (phase == 3'd2) ? ($urandom % 5 == 0) : ($urandom % 9 == 0));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule